// File: doc/BRIEF.md
# Waveform RAM Command Sequencer

This block keeps a host-loaded waveform in on-chip RAM and replays it as a stream of internal register-write commands. A small host register port sets the command target (card address, parameter identifier, words per command), the step period, the sequence length, the operating mode and an access pointer. Waveform samples go in and come out through a data register that steps the access pointer on every access.

When the mode register holds the waveform value, a sequencer walks the RAM from index zero to length-1 and wraps. It sends one command per step and waits a programmed number of frame ticks between steps. Each command is offered on a valid/ready handshake. The sample most recently accepted is presented on a header output for the next outgoing packet. In internal-ramp mode, the header output carries an external ramp value instead.

The sequencer has four named states. SQ_IDLE waits for playback to be enabled and moves to SQ_FETCH. SQ_FETCH reads the RAM at the playback index, captures the target fields and moves to SQ_ISSUE. SQ_ISSUE holds the command valid and moves to SQ_WAIT on acceptance. SQ_WAIT counts frame ticks and returns to SQ_FETCH after the period has elapsed. From any state, loss of enable returns the sequencer to SQ_IDLE.

Top module: `wfm_cmd_seq`

## Requirements
- R1: After reset, cmd_valid, host_rvalid and hdr_value are 0, and every register and the access pointer are 0.
- R2: A host write with select 3 (data) stores host_wdata at the access pointer and then increments the pointer, wrapping modulo DEPTH. The pointer never resets by itself, so a later series of data writes continues after the earlier ones.
- R3: A host read (host_re high, host_we low) raises host_rvalid one cycle later, with host_rdata holding the selected value. A data read returns the RAM entry at the access pointer and then increments the pointer. A write with select 2 loads the access pointer.
- R4: Loading the access pointer has no effect on the playback index.
- R5: Playback is enabled when the mode register (select 0, bits 1:0) equals 3 and the effective length is nonzero. On enable, the first command carries RAM entry 0. Later commands carry entries 1, 2 and onward up to length-1, and then wrap to entry 0.
- R6: A length register (select 1) of 0 disables playback. A length above DEPTH acts as DEPTH.
- R7: After a command is accepted, the next command is offered only after P frame ticks, where P is the period register (select 4) and a value of 0 counts as 1. Frame ticks that arrive while a command is pending or being fetched are not counted.
- R8: Each command carries the card address (select 6), the parameter identifier (select 5) and the word count (select 7), all captured when the sample is fetched. While cmd_valid is high and cmd_ready is low, the command and its payload stay unchanged.
- R9: hdr_value equals the sample most recently accepted, except in mode 2, where it equals ramp_value.
- R10: When playback is disabled, cmd_valid falls on the next cycle and the playback index and frame count return to 0. A later enable restarts at entry 0.
- R11: The register selects are: 0 mode, 1 length, 2 pointer, 3 data, 4 period, 5 parameter identifier, 6 card address, 7 word count. A read of any select other than data returns the stored value, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe (ignored when host_we is high) |
| host_sel | input | 3 | Register select |
| host_wdata | input | REG_W | Host write data |
| host_rvalid | output | 1 | Read data valid, one cycle after host_re |
| host_rdata | output | REG_W | Read data |
| frame_tick | input | 1 | One pulse per frame period |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Command accepted when high together with cmd_valid |
| cmd_card | output | REG_W | Target card address |
| cmd_param | output | REG_W | Target parameter identifier |
| cmd_count | output | REG_W | Data words per command |
| cmd_sample | output | REG_W | Waveform sample carried by the command |
| ramp_value | input | REG_W | Value reported in the header slot during mode 2 |
| hdr_value | output | REG_W | Value for the packet header slot |

## Verification
The embedded assertions check the following on every cycle: a pending command and its payload hold stable until accepted, an accepted command is followed by an idle cycle, a read strobe produces a valid pulse, a data write steps the pointer, and disable or zero length drops cmd_valid. An enable edge is also checked to start a fetch at index zero. Other behaviours can only be shown by the bench's scenarios against its per-cycle model. These are the order of replayed samples and their wrap at the clamped length, the spacing of commands in frame ticks, the independence of the access pointer from playback, append-on-write, restart after re-enable, and the header value in the two modes.

// File: rtl/wfm_pkg.sv
package wfm_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_ISSUE = 2'd2,
        SQ_WAIT  = 2'd3
    } seq_state_t;

    typedef enum logic [2:0] {
        RS_MODE   = 3'd0,
        RS_LEN    = 3'd1,
        RS_PTR    = 3'd2,
        RS_DATA   = 3'd3,
        RS_PERIOD = 3'd4,
        RS_PARAM  = 3'd5,
        RS_CARD   = 3'd6,
        RS_COUNT  = 3'd7
    } reg_sel_t;

    localparam logic [1:0] MODE_RAMP = 2'd2;
    localparam logic [1:0] MODE_WAVE = 2'd3;

endpackage

// File: rtl/wfm_ram.sv
module wfm_ram #(
    parameter int DEPTH  = 1024,
    parameter int DATA_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re_a,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic              re_b,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Reads return the value held before a same-cycle write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re_a) begin
            rdata_a <= mem[raddr_a];
        end
        if (re_b) begin
            rdata_b <= mem[raddr_b];
        end
    end

endmodule

// File: rtl/wfm_host_regs.sv
module wfm_host_regs
    import wfm_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int REG_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_re,
    input  logic [2:0]        host_sel,
    input  logic [REG_W-1:0]  host_wdata,
    output logic              host_rvalid,
    output logic [REG_W-1:0]  host_rdata,
    output logic [1:0]        mode_q,
    output logic [REG_W-1:0]  len_q,
    output logic [REG_W-1:0]  period_q,
    output logic [REG_W-1:0]  param_q,
    output logic [REG_W-1:0]  card_q,
    output logic [REG_W-1:0]  count_q,
    output logic              ram_we,
    output logic              ram_re,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [REG_W-1:0]  ram_wdata,
    input  logic [REG_W-1:0]  ram_rdata
);

    reg_sel_t           sel;
    logic [ADDR_W-1:0]  ptr_q;
    logic [REG_W-1:0]   rd_val;
    logic [REG_W-1:0]   val_q;
    logic               from_ram_q;
    logic               rd_go;

    assign sel       = reg_sel_t'(host_sel);
    assign rd_go     = host_re && !host_we;
    assign ram_we    = host_we && (sel == RS_DATA);
    assign ram_re    = rd_go && (sel == RS_DATA);
    assign ram_addr  = ptr_q;
    assign ram_wdata = host_wdata;

    always_comb begin
        unique case (sel)
            RS_MODE:   rd_val = REG_W'(mode_q);
            RS_LEN:    rd_val = len_q;
            RS_PTR:    rd_val = REG_W'(ptr_q);
            RS_DATA:   rd_val = '0;
            RS_PERIOD: rd_val = period_q;
            RS_PARAM:  rd_val = param_q;
            RS_CARD:   rd_val = card_q;
            RS_COUNT:  rd_val = count_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= '0;
            len_q       <= '0;
            period_q    <= '0;
            param_q     <= '0;
            card_q      <= '0;
            count_q     <= '0;
            ptr_q       <= '0;
            val_q       <= '0;
            from_ram_q  <= 1'b0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= rd_go;
            from_ram_q  <= rd_go && (sel == RS_DATA);
            if (host_we) begin
                unique case (sel)
                    RS_MODE:   mode_q   <= host_wdata[1:0];
                    RS_LEN:    len_q    <= host_wdata;
                    RS_PTR:    ptr_q    <= host_wdata[ADDR_W-1:0];
                    RS_DATA:   ptr_q    <= ptr_q + 1'b1;
                    RS_PERIOD: period_q <= host_wdata;
                    RS_PARAM:  param_q  <= host_wdata;
                    RS_CARD:   card_q   <= host_wdata;
                    RS_COUNT:  count_q  <= host_wdata;
                endcase
            end else if (host_re) begin
                val_q <= rd_val;
                if (sel == RS_DATA) begin
                    ptr_q <= ptr_q + 1'b1;
                end
            end
        end
    end

    assign host_rdata = from_ram_q ? ram_rdata : val_q;

    // R2: a data write advances the access pointer by one
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_sel == 3'd3) |=> (ptr_q == $past(ptr_q) + 1'b1));

    // R3: a read strobe yields a valid pulse on the next cycle
    a_r3_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && !host_we) |=> host_rvalid);

endmodule

// File: rtl/wfm_player.sv
module wfm_player
    import wfm_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int REG_W = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [REG_W-1:0]  len_i,
    input  logic [REG_W-1:0]  period_i,
    input  logic [REG_W-1:0]  param_i,
    input  logic [REG_W-1:0]  card_i,
    input  logic [REG_W-1:0]  count_i,
    input  logic              frame_tick,
    output logic              ram_re,
    output logic [ADDR_W-1:0] ram_raddr,
    input  logic [REG_W-1:0]  ram_rdata,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [REG_W-1:0]  cmd_card,
    output logic [REG_W-1:0]  cmd_param,
    output logic [REG_W-1:0]  cmd_count,
    output logic [REG_W-1:0]  cmd_sample,
    output logic [REG_W-1:0]  hdr_awg
);

    localparam logic [REG_W-1:0] DEPTH_R = REG_W'(DEPTH);

    seq_state_t         state_q, state_d;
    logic [LEN_W-1:0]   len_eff;
    logic [REG_W-1:0]   per_eff;
    logic               active;
    logic [ADDR_W-1:0]  idx_q;
    logic [LEN_W-1:0]   idx_nx;
    logic [REG_W-1:0]   cnt_q;
    logic [REG_W-1:0]   cnt_nx;
    logic               tick_last;

    always_comb begin
        if (len_i > DEPTH_R) begin
            len_eff = LEN_W'(DEPTH);
        end else begin
            len_eff = len_i[LEN_W-1:0];
        end
    end

    assign per_eff   = (period_i == '0) ? REG_W'(1) : period_i;
    assign active    = (mode_i == MODE_WAVE) && (len_eff != '0);
    assign idx_nx    = {1'b0, idx_q} + LEN_W'(1);
    assign cnt_nx    = cnt_q + REG_W'(1);
    assign tick_last = (cnt_nx >= per_eff);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = SQ_IDLE;
        end else begin
            unique case (state_q)
                SQ_IDLE:  state_d = SQ_FETCH;
                SQ_FETCH: state_d = SQ_ISSUE;
                SQ_ISSUE: if (cmd_ready) state_d = SQ_WAIT;
                SQ_WAIT:  if (frame_tick && tick_last) state_d = SQ_FETCH;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        cmd_valid = (state_q == SQ_ISSUE);
        ram_re    = (state_q == SQ_FETCH);
        ram_raddr = idx_q;
    end

    assign cmd_sample = ram_rdata;

    // Playback index, frame count and captured payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            cnt_q     <= '0;
            cmd_card  <= '0;
            cmd_param <= '0;
            cmd_count <= '0;
            hdr_awg   <= '0;
        end else if (!active) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    idx_q <= '0;
                    cnt_q <= '0;
                end
                SQ_FETCH: begin
                    cmd_card  <= card_i;
                    cmd_param <= param_i;
                    cmd_count <= count_i;
                end
                SQ_ISSUE: begin
                    if (cmd_ready) begin
                        hdr_awg <= ram_rdata;
                        cnt_q   <= '0;
                        if (idx_nx >= len_eff) begin
                            idx_q <= '0;
                        end else begin
                            idx_q <= idx_nx[ADDR_W-1:0];
                        end
                    end
                end
                SQ_WAIT: begin
                    if (frame_tick) begin
                        cnt_q <= tick_last ? '0 : cnt_nx;
                    end
                end
            endcase
        end
    end

    // R8: a pending command and its payload hold until accepted
    a_r8_hold_pending: assert property (@(posedge clk) disable iff (!rst_n || !active)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_sample) &&
            $stable(cmd_card) && $stable(cmd_param) && $stable(cmd_count)));

    // R7: an accepted command is followed by waiting, not a new offer
    a_r7_gap_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && active) |=> !cmd_valid);

    // R10: disabling playback drops the offer on the next cycle
    a_r10_drop_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_WAVE) |=> !cmd_valid);

    // R6: a zero length keeps the sequencer quiet
    a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (len_i == '0) |=> !cmd_valid);

    // R5: enabling starts a fetch at entry zero
    a_r5_start_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |=> (state_q == SQ_FETCH && idx_q == '0));

endmodule

// File: rtl/wfm_cmd_seq.sv
module wfm_cmd_seq
    import wfm_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic             host_re,
    input  logic [2:0]       host_sel,
    input  logic [REG_W-1:0] host_wdata,
    output logic             host_rvalid,
    output logic [REG_W-1:0] host_rdata,
    input  logic             frame_tick,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [REG_W-1:0] cmd_card,
    output logic [REG_W-1:0] cmd_param,
    output logic [REG_W-1:0] cmd_count,
    output logic [REG_W-1:0] cmd_sample,
    input  logic [REG_W-1:0] ramp_value,
    output logic [REG_W-1:0] hdr_value
);

    localparam int ADDR_W = $clog2(DEPTH);

    logic [1:0]        mode_q;
    logic [REG_W-1:0]  len_q, period_q, param_q, card_q, count_q;
    logic              h_we, h_re;
    logic [ADDR_W-1:0] h_addr;
    logic [REG_W-1:0]  h_wdata, h_rdata;
    logic              p_re;
    logic [ADDR_W-1:0] p_addr;
    logic [REG_W-1:0]  p_rdata;
    logic [REG_W-1:0]  hdr_awg;

    wfm_host_regs #(.DEPTH(DEPTH), .REG_W(REG_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .host_rvalid(host_rvalid),
        .host_rdata (host_rdata),
        .mode_q     (mode_q),
        .len_q      (len_q),
        .period_q   (period_q),
        .param_q    (param_q),
        .card_q     (card_q),
        .count_q    (count_q),
        .ram_we     (h_we),
        .ram_re     (h_re),
        .ram_addr   (h_addr),
        .ram_wdata  (h_wdata),
        .ram_rdata  (h_rdata)
    );

    wfm_ram #(.DEPTH(DEPTH), .DATA_W(REG_W)) u_ram (
        .clk    (clk),
        .we     (h_we),
        .waddr  (h_addr),
        .wdata  (h_wdata),
        .re_a   (h_re),
        .raddr_a(h_addr),
        .rdata_a(h_rdata),
        .re_b   (p_re),
        .raddr_b(p_addr),
        .rdata_b(p_rdata)
    );

    wfm_player #(.DEPTH(DEPTH), .REG_W(REG_W)) u_player (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_q),
        .len_i     (len_q),
        .period_i  (period_q),
        .param_i   (param_q),
        .card_i    (card_q),
        .count_i   (count_q),
        .frame_tick(frame_tick),
        .ram_re    (p_re),
        .ram_raddr (p_addr),
        .ram_rdata (p_rdata),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_card  (cmd_card),
        .cmd_param (cmd_param),
        .cmd_count (cmd_count),
        .cmd_sample(cmd_sample),
        .hdr_awg   (hdr_awg)
    );

    // R9: header slot shared between waveform and ramp modes
    assign hdr_value = (mode_q == MODE_RAMP) ? ramp_value : hdr_awg;

endmodule

// File: tb/wfm_cmd_seq_bench.sv
module wfm_cmd_seq_bench;

    localparam int B_DEPTH = 16;
    localparam int B_W     = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           host_we = 1'b0;
    logic           host_re = 1'b0;
    logic [2:0]     host_sel = '0;
    logic [B_W-1:0] host_wdata = '0;
    logic           host_rvalid;
    logic [B_W-1:0] host_rdata;
    logic           frame_tick = 1'b0;
    logic           cmd_valid;
    logic           cmd_ready = 1'b1;
    logic [B_W-1:0] cmd_card, cmd_param, cmd_count, cmd_sample;
    logic [B_W-1:0] ramp_value = '0;
    logic [B_W-1:0] hdr_value;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    int tick_div = 0;
    int cyc_n = 0;

    // reference model state
    int m_mode, m_len, m_ptr, m_per, m_par, m_card, m_cnt_reg;
    int mem [B_DEPTH];
    int m_rvalid, m_rdata;
    int m_st, m_idx, m_cnt, m_q, m_c_card, m_c_par, m_c_cnt, m_hdr;
    int acc[$];

    always #4 clk = ~clk;

    wfm_cmd_seq #(.DEPTH(B_DEPTH), .REG_W(B_W)) u_wfm_cmd_seq (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_re(host_re), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .frame_tick(frame_tick), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_card(cmd_card), .cmd_param(cmd_param), .cmd_count(cmd_count),
        .cmd_sample(cmd_sample), .ramp_value(ramp_value), .hdr_value(hdr_value)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_len = 0; m_ptr = 0; m_per = 0; m_par = 0; m_card = 0;
            m_cnt_reg = 0; m_rvalid = 0; m_rdata = 0; m_st = 0; m_idx = 0;
            m_cnt = 0; m_q = 0; m_c_card = 0; m_c_par = 0; m_c_cnt = 0; m_hdr = 0;
        end else begin
            int leff, per;
            bit act;
            leff = (m_len > B_DEPTH) ? B_DEPTH : m_len;
            per  = (m_per == 0) ? 1 : m_per;
            act  = (m_mode == 3) && (leff != 0);
            if (!act) begin
                m_st = 0; m_idx = 0; m_cnt = 0;
            end else if (m_st == 0) begin
                m_st = 1; m_idx = 0; m_cnt = 0;
            end else if (m_st == 1) begin
                m_q = mem[m_idx]; m_c_card = m_card; m_c_par = m_par;
                m_c_cnt = m_cnt_reg; m_st = 2;
            end else if (m_st == 2) begin
                if (cmd_ready) begin
                    m_hdr = m_q; acc.push_back(m_q);
                    m_idx = (m_idx + 1 >= leff) ? 0 : m_idx + 1;
                    m_cnt = 0; m_st = 3;
                end
            end else begin
                if (frame_tick) begin
                    if (m_cnt + 1 >= per) begin m_cnt = 0; m_st = 1; end
                    else m_cnt = m_cnt + 1;
                end
            end
            m_rvalid = (host_re && !host_we) ? 1 : 0;
            if (host_we) begin
                case (host_sel)
                    3'd0: m_mode = host_wdata & 3;
                    3'd1: m_len = host_wdata;
                    3'd2: m_ptr = host_wdata % B_DEPTH;
                    3'd3: begin mem[m_ptr] = host_wdata; m_ptr = (m_ptr + 1) % B_DEPTH; end
                    3'd4: m_per = host_wdata;
                    3'd5: m_par = host_wdata;
                    3'd6: m_card = host_wdata;
                    default: m_cnt_reg = host_wdata;
                endcase
            end else if (host_re) begin
                case (host_sel)
                    3'd0: m_rdata = m_mode;
                    3'd1: m_rdata = m_len;
                    3'd2: m_rdata = m_ptr;
                    3'd3: begin m_rdata = mem[m_ptr]; m_ptr = (m_ptr + 1) % B_DEPTH; end
                    3'd4: m_rdata = m_per;
                    3'd5: m_rdata = m_par;
                    3'd6: m_rdata = m_card;
                    default: m_rdata = m_cnt_reg;
                endcase
            end
        end
    end

    // cycle compare, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5", "cmd_valid", {31'd0, cmd_valid}, (m_st == 2) ? 1 : 0);
            if (cmd_valid) begin
                chk("R5", "cmd_sample", {16'd0, cmd_sample}, m_q);
                chk("R8", "cmd_card", {16'd0, cmd_card}, m_c_card);
                chk("R8", "cmd_param", {16'd0, cmd_param}, m_c_par);
                chk("R8", "cmd_count", {16'd0, cmd_count}, m_c_cnt);
            end
            chk("R3", "host_rvalid", {31'd0, host_rvalid}, m_rvalid);
            if (host_rvalid) chk("R3", "host_rdata", {16'd0, host_rdata}, m_rdata);
            chk("R9", "hdr_value", {16'd0, hdr_value},
                (m_mode == 2) ? int'(ramp_value) : m_hdr);
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
        frame_tick = (tick_div != 0) && (cyc_n % tick_div == 0);
        cyc_n++;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic hwr(input int sel, input int val);
        host_we = 1'b1; host_sel = 3'(sel); host_wdata = B_W'(val);
        cyc();
        host_we = 1'b0;
    endtask

    task automatic hrd(input int sel, input string tag, input int exp);
        host_re = 1'b1; host_sel = 3'(sel);
        cyc();
        host_re = 1'b0;
        @(negedge clk);
        chk(tag, "readback", {16'd0, host_rdata}, exp);
    endtask

    task automatic wait_acc(input int n, input int limit);
        for (int i = 0; i < limit && acc.size() < n; i++) cyc();
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "cmd_valid", {31'd0, cmd_valid}, 0);
        chk("R1", "hdr_value", {16'd0, hdr_value}, 0);
        chk("R1", "host_rvalid", {31'd0, host_rvalid}, 0);
        cyc();

        // R2: append across two bursts, R3/R11 readback
        hwr(2, 0);
        for (int i = 0; i < 8; i++) hwr(3, 100 + i);
        run(3);
        for (int i = 8; i < 16; i++) hwr(3, 100 + i);
        hrd(2, "R2", 0);
        hwr(2, 0);
        hrd(3, "R3", 100);
        hrd(3, "R3", 101);
        hwr(2, 8);
        hrd(3, "R2", 108);
        hwr(6, 2); hwr(5, 153); hwr(7, 1);
        hrd(6, "R11", 2);
        hrd(5, "R11", 153);

        // R5: playback order and wrap, R4: pointer moves during play
        hwr(4, 2); hwr(1, 4);
        tick_div = 2;
        acc.delete();
        hwr(0, 3);
        wait_acc(2, 200);
        hwr(2, 9);
        wait_acc(6, 400);
        chk("R5", "first sample", acc[0], 100);
        chk("R5", "wrap sample", acc[4], 100);
        chk("R4", "order kept", acc[5], 101);
        chk("R5", "last before wrap", acc[3], 103);

        // R8: backpressure
        cmd_ready = 1'b0;
        run(20);
        @(negedge clk);
        chk("R8", "held valid", {31'd0, cmd_valid}, 1);
        tick_div = 0;
        acc.delete();
        cmd_ready = 1'b1;
        run(40);
        // R7: no ticks, no further commands
        chk("R7", "accepts without ticks", acc.size(), 1);

        // R10: disable and re-enable restarts at zero
        hwr(0, 0);
        @(negedge clk);
        chk("R10", "valid after disable", {31'd0, cmd_valid}, 0);
        acc.delete();
        tick_div = 1;
        hwr(0, 3);
        wait_acc(1, 100);
        chk("R10", "restart sample", acc[0], 100);

        // R6: zero length, then clamp
        hwr(1, 0);
        run(3);
        acc.delete();
        run(40);
        chk("R6", "zero length accepts", acc.size(), 0);
        hwr(4, 0);
        hwr(1, 100);
        wait_acc(17, 400);
        chk("R6", "clamped last", acc[15], 115);
        chk("R6", "clamped wrap", acc[16], 100);

        // R9: header slot in ramp mode
        ramp_value = 16'h55AA;
        hwr(0, 2);
        @(negedge clk);
        chk("R9", "ramp header", {16'd0, hdr_value}, 32'h55AA);
        run(4);
        finish_run();
    end

endmodule